// File: doc/BRIEF.md
# NAND Target Command Sequencer

This block models the command side of a NAND flash target. It receives command-latch and address-latch byte events, one at a time. From them it steps through power-on, a reset wait, idle, identification read, parameter page read, page read, page program and block erase. It gathers the column and row address bytes into little-endian accumulators. The number of bytes in each comes from a packed configuration byte. The block keeps a two-bit status (ready and fail) and holds ready low for a programmable number of cycles per operation.

Its result is a data-window descriptor: a kind code, a length, a column and a row. A separate data path uses it to move bytes to or from storage. The storage itself, ECC and bus timing live outside this block. An event the current state does not expect never hangs the sequencer. It raises a one-cycle error pulse and the sequencer falls back to idle.

Top module: `nand_cmd_seq`

## Requirements
- R1: After rstN the status reads {wpN, 1, 00000, 0} (RDY on bit 6, FAIL on bit 0), the window kind is 0 and both error pulses are low. In the power-on state only command 0xFF is accepted. Any other command or address byte pulses undefErr and moves the sequencer to idle.
- R2: Command 0xFF in the power-on state clears the window (kind 0) and holds RDY low for exactly RST_CYCLES cycles. The sequencer is then idle with RDY high.
- R3: Every command received in idle first clears FAIL. The accepted commands are 0x90 (ID), 0xEC (parameter), 0x00 (read), 0x80 (program) and 0x60 (erase). Any other command, including 0xFF, pulses undefErr and the sequencer stays in idle.
- R4: cycleCfg[3:0] gives the number of row address bytes and cycleCfg[7:4] gives the number of column address bytes. The first byte received lands in bits [7:0] of its accumulator, the next in bits [15:8], and so on.
- R5: After 0x90, address 0x00 gives window kind 1 with length 2. Address 0x20 gives kind 2 with length 4. Any other address pulses addrErr and leaves the window unchanged. In all three cases the sequencer returns to idle.
- R6: After 0xEC, address 0x00 gives window kind 3 with length PARAM_BYTES. Any other address pulses addrErr. In both cases the sequencer returns to idle.
- R7: A read takes its column bytes, then its row bytes, then the confirm 0x30. With readDelay N > 0, RDY is low for exactly N cycles. When RDY rises the window becomes kind 4 with length PAGE_BYTES+SPARE_BYTES and the gathered column and row. With N = 0, RDY stays high and the window is set at once.
- R8: A program takes its column bytes, then its row bytes, and the window (kind 4) is set once the row is complete. The confirm 0x10 holds RDY low for progDelay cycles.
- R9: An erase takes row bytes only. It sets window kind 5 with length (PAGE_BYTES+SPARE_BYTES)*PAGES_PER_BLK, column 0 and the gathered row. The confirm 0xD0 holds RDY low for eraseDelay cycles.
- R10: A block is invalid when the row has bits set above the block field, or when its badBlkMap bit is set. The block field is row[PAGE_BITS +: BLK_BITS]. For program or erase to an invalid block, the block sets FAIL and the window kind becomes 0 once the last row byte is in. For a read of an invalid block, the window kind becomes 0 at completion and FAIL stays clear.
- R11: Address bytes that arrive after the address phase is complete are ignored. The window is unchanged and the following confirm behaves normally.
- R12: In any operation state, a command that is not the expected one pulses undefErr and returns the sequencer to idle. So does any event received while RDY is low, which also sets RDY at once.
- R13: Status bit 7 follows the wpN input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte event |
| cmdByte | input | 8 | Command opcode |
| addrValid | input | 1 | Address byte event |
| addrByte | input | 8 | Address byte |
| cycleCfg | input | 8 | Column count (high nibble), row count (low nibble) |
| readDelay | input | DLY_W | Busy cycles for read |
| progDelay | input | DLY_W | Busy cycles for program |
| eraseDelay | input | DLY_W | Busy cycles for erase |
| badBlkMap | input | NUM_BLOCKS | One bit per block, 1 marks a bad block |
| wpN | input | 1 | Write-protect level shown on status bit 7 |
| status | output | 8 | {wpN, RDY, 00000, FAIL} |
| winKind | output | 3 | 0 none, 1 ID, 2 signature, 3 parameter, 4 page, 5 block |
| winLen | output | LEN_W | Window length in bytes |
| winCol | output | 8*COL_BYTES | Window start column |
| winRow | output | 8*ROW_BYTES | Window row |
| undefErr | output | 1 | One-cycle pulse on an unexpected event |
| addrErr | output | 1 | One-cycle pulse on an out-of-range ID or parameter address |

## Verification
The assertions take the input side as well-behaved. cmdValid and addrValid are never high together, and every event is followed by at least one cycle with no event, so the cycle that checks the block never coincides with a new byte. Each nibble of cycleCfg is between 1 and the capacity of its accumulator and stays steady during an operation. The bench drives each event for one cycle and always drops both valids before the next one. It draws random nibbles only in the range 1..COL_BYTES or 1..ROW_BYTES. Random delays, row values and bad-block maps are drawn so that both valid and invalid blocks come up.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [7:0] CMD_RESET    = 8'hFF;
  localparam logic [7:0] CMD_ID       = 8'h90;
  localparam logic [7:0] CMD_PARAM    = 8'hEC;
  localparam logic [7:0] CMD_READ     = 8'h00;
  localparam logic [7:0] CMD_READ_GO  = 8'h30;
  localparam logic [7:0] CMD_PROG     = 8'h80;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] SIG_ADDR     = 8'h20;

  typedef enum logic [2:0] {
    WIN_NONE  = 3'd0,
    WIN_ID    = 3'd1,
    WIN_SIG   = 3'd2,
    WIN_PARAM = 3'd3,
    WIN_PAGE  = 3'd4,
    WIN_BLOCK = 3'd5
  } winKind_t;

  typedef enum logic [1:0] {
    DLY_RST, DLY_READ, DLY_PROG, DLY_ERASE
  } dlySel_t;

  typedef enum logic [3:0] {
    S_POWERON, S_RSTBUSY, S_IDLE, S_ID, S_PARAM,
    S_RD_COL, S_RD_ROW, S_RD_CONF,
    S_PG_COL, S_PG_ROW, S_PG_CHK, S_PG_CONF,
    S_ER_ROW, S_ER_CHK, S_ER_CONF, S_BUSY
  } seqState_t;

  typedef struct packed {
    logic     addrClr;
    logic     colTake;
    logic     rowTake;
    logic     failClr;
    logic     failSet;
    logic     rdyClr;
    logic     rdySet;
    logic     timerLoad;
    dlySel_t  timerSel;
    logic     winClr;
    logic     winLoad;
    winKind_t winKind;
  } seqStb_t;

endpackage

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES    = 512,
  parameter int SPARE_BYTES   = 16,
  parameter int PAGES_PER_BLK = 64,
  parameter int NUM_BLOCKS    = 16,
  parameter int COL_BYTES     = 2,
  parameter int ROW_BYTES     = 3,
  parameter int PARAM_BYTES   = 256,
  parameter int DLY_W         = 12,
  parameter int RST_CYCLES    = 8,
  parameter int LEN_W         = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStb_t               stb,
  input  logic [7:0]            addrByte,
  input  logic [7:0]            cycleCfg,
  input  logic [DLY_W-1:0]      readDelay,
  input  logic [DLY_W-1:0]      progDelay,
  input  logic [DLY_W-1:0]      eraseDelay,
  input  logic [NUM_BLOCKS-1:0] badBlkMap,
  input  logic                  wpN,
  output logic                  colLast,
  output logic                  rowLast,
  output logic                  timerLast,
  output logic                  blkOk,
  output logic [2:0]            zeroDly,
  output logic                  rdy,
  output logic [7:0]            status,
  output winKind_t              winKind,
  output logic [LEN_W-1:0]      winLen,
  output logic [8*COL_BYTES-1:0] winCol,
  output logic [8*ROW_BYTES-1:0] winRow
);

  localparam int COL_W      = 8 * COL_BYTES;
  localparam int ROW_W      = 8 * ROW_BYTES;
  localparam int PAGE_BITS  = $clog2(PAGES_PER_BLK);
  localparam int BLK_BITS   = $clog2(NUM_BLOCKS);
  localparam int PAGE_TOTAL = PAGE_BYTES + SPARE_BYTES;
  localparam int BLK_TOTAL  = PAGE_TOTAL * PAGES_PER_BLK;

  logic [3:0]       addrCnt;
  logic [COL_W-1:0] colAcc;
  logic [ROW_W-1:0] rowAcc;
  logic [DLY_W-1:0] timer;
  logic [DLY_W-1:0] dlyVal;
  logic             failBit;
  logic [LEN_W-1:0] lenOf;

  assign colLast = (addrCnt + 4'd1) == cycleCfg[7:4];
  assign rowLast = (addrCnt + 4'd1) == cycleCfg[3:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt <= '0;
      colAcc  <= '0;
      rowAcc  <= '0;
    end else if (stb.addrClr) begin
      addrCnt <= '0;
      colAcc  <= '0;
      rowAcc  <= '0;
    end else if (stb.colTake) begin
      for (int k = 0; k < COL_BYTES; k++)
        if (addrCnt == 4'(k)) colAcc[8*k +: 8] <= addrByte;
      addrCnt <= colLast ? 4'd0 : addrCnt + 4'd1;
    end else if (stb.rowTake) begin
      for (int k = 0; k < ROW_BYTES; k++)
        if (addrCnt == 4'(k)) rowAcc[8*k +: 8] <= addrByte;
      addrCnt <= rowLast ? 4'd0 : addrCnt + 4'd1;
    end
  end

  assign blkOk = ((rowAcc >> (PAGE_BITS + BLK_BITS)) == '0) &&
                 !badBlkMap[rowAcc[PAGE_BITS +: BLK_BITS]];

  assign zeroDly = {eraseDelay == '0, progDelay == '0, readDelay == '0};

  always_comb begin
    unique case (stb.timerSel)
      DLY_READ:  dlyVal = readDelay;
      DLY_PROG:  dlyVal = progDelay;
      DLY_ERASE: dlyVal = eraseDelay;
      default:   dlyVal = DLY_W'(RST_CYCLES);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               timer <= '0;
    else if (stb.timerLoad)  timer <= dlyVal;
    else if (timer != '0)    timer <= timer - 1'b1;
  end

  assign timerLast = (timer == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdy     <= 1'b1;
      failBit <= 1'b0;
    end else begin
      if (stb.rdyClr)      rdy <= 1'b0;
      else if (stb.rdySet) rdy <= 1'b1;
      if (stb.failSet)      failBit <= 1'b1;
      else if (stb.failClr) failBit <= 1'b0;
    end
  end

  assign status = {wpN, rdy, 5'b0, failBit};

  always_comb begin
    unique case (stb.winKind)
      WIN_ID:    lenOf = LEN_W'(2);
      WIN_SIG:   lenOf = LEN_W'(4);
      WIN_PARAM: lenOf = LEN_W'(PARAM_BYTES);
      WIN_PAGE:  lenOf = LEN_W'(PAGE_TOTAL);
      WIN_BLOCK: lenOf = LEN_W'(BLK_TOTAL);
      default:   lenOf = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winKind <= WIN_NONE;
      winLen  <= '0;
      winCol  <= '0;
      winRow  <= '0;
    end else if (stb.winClr) begin
      winKind <= WIN_NONE;
    end else if (stb.winLoad) begin
      winKind <= stb.winKind;
      winLen  <= lenOf;
      winCol  <= (stb.winKind == WIN_PAGE) ? colAcc : '0;
      winRow  <= (stb.winKind == WIN_PAGE || stb.winKind == WIN_BLOCK) ? rowAcc : '0;
    end
  end

  // R10
  fail_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failBit) |-> !blkOk);

  // R4
  take_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.colTake, stb.rowTake, stb.addrClr}));

  // R9
  win_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.winLoad, stb.winClr}));

endmodule

// File: rtl/nand_seq_ctl.sv
module nand_seq_ctl
  import nand_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       addrValid,
  input  logic [7:0] addrByte,
  input  logic       colLast,
  input  logic       rowLast,
  input  logic       timerLast,
  input  logic       blkOk,
  input  logic [2:0] zeroDly,
  input  logic       rdy,
  output seqStb_t    stb,
  output logic       undefErr,
  output logic       addrErr
);

  seqState_t state, nxt;
  logic opRead;
  logic undefN, addrErrN;
  logic anyEv;

  assign anyEv = cmdValid | addrValid;

  always_comb begin
    stb      = '0;
    nxt      = state;
    undefN   = 1'b0;
    addrErrN = 1'b0;
    unique case (state)
      S_POWERON: begin
        if (cmdValid && cmdByte == CMD_RESET) begin
          stb.winClr    = 1'b1;
          stb.rdyClr    = 1'b1;
          stb.timerLoad = 1'b1;
          stb.timerSel  = DLY_RST;
          nxt           = S_RSTBUSY;
        end else if (anyEv) begin
          undefN = 1'b1;
          nxt    = S_IDLE;
        end
      end
      S_RSTBUSY, S_BUSY: begin
        if (anyEv) begin
          undefN     = 1'b1;
          stb.rdySet = 1'b1;
          nxt        = S_IDLE;
        end else if (timerLast) begin
          stb.rdySet = 1'b1;
          nxt        = S_IDLE;
          if (state == S_BUSY && opRead) begin
            if (blkOk) begin
              stb.winLoad = 1'b1;
              stb.winKind = WIN_PAGE;
            end else begin
              stb.winClr = 1'b1;
            end
          end
        end
      end
      S_IDLE: begin
        if (cmdValid) begin
          stb.failClr = 1'b1;
          unique case (cmdByte)
            CMD_ID:    nxt = S_ID;
            CMD_PARAM: nxt = S_PARAM;
            CMD_READ:  begin stb.addrClr = 1'b1; nxt = S_RD_COL; end
            CMD_PROG:  begin stb.addrClr = 1'b1; nxt = S_PG_COL; end
            CMD_ERASE: begin stb.addrClr = 1'b1; nxt = S_ER_ROW; end
            default:   undefN = 1'b1;
          endcase
        end else if (addrValid) begin
          undefN = 1'b1;
        end
      end
      S_ID, S_PARAM: begin
        if (addrValid) begin
          nxt = S_IDLE;
          if (addrByte == 8'h00) begin
            stb.winLoad = 1'b1;
            stb.winKind = (state == S_ID) ? WIN_ID : WIN_PARAM;
          end else if (state == S_ID && addrByte == SIG_ADDR) begin
            stb.winLoad = 1'b1;
            stb.winKind = WIN_SIG;
          end else begin
            addrErrN = 1'b1;
          end
        end else if (cmdValid) begin
          undefN = 1'b1;
          nxt    = S_IDLE;
        end
      end
      S_RD_COL, S_PG_COL: begin
        if (addrValid) begin
          stb.colTake = 1'b1;
          if (colLast) nxt = (state == S_RD_COL) ? S_RD_ROW : S_PG_ROW;
        end else if (cmdValid) begin
          undefN = 1'b1;
          nxt    = S_IDLE;
        end
      end
      S_RD_ROW, S_PG_ROW, S_ER_ROW: begin
        if (addrValid) begin
          stb.rowTake = 1'b1;
          if (rowLast) begin
            if (state == S_RD_ROW)      nxt = S_RD_CONF;
            else if (state == S_PG_ROW) nxt = S_PG_CHK;
            else                        nxt = S_ER_CHK;
          end
        end else if (cmdValid) begin
          undefN = 1'b1;
          nxt    = S_IDLE;
        end
      end
      S_PG_CHK, S_ER_CHK: begin
        if (blkOk) begin
          stb.winLoad = 1'b1;
          stb.winKind = (state == S_PG_CHK) ? WIN_PAGE : WIN_BLOCK;
        end else begin
          stb.winClr  = 1'b1;
          stb.failSet = 1'b1;
        end
        nxt = (state == S_PG_CHK) ? S_PG_CONF : S_ER_CONF;
      end
      S_RD_CONF, S_PG_CONF, S_ER_CONF: begin
        if (cmdValid) begin
          if ((state == S_RD_CONF && cmdByte == CMD_READ_GO) ||
              (state == S_PG_CONF && cmdByte == CMD_PROG_GO) ||
              (state == S_ER_CONF && cmdByte == CMD_ERASE_GO)) begin
            if ((state == S_RD_CONF && zeroDly[0]) ||
                (state == S_PG_CONF && zeroDly[1]) ||
                (state == S_ER_CONF && zeroDly[2])) begin
              stb.rdySet = 1'b1;
              nxt        = S_IDLE;
              if (state == S_RD_CONF) begin
                if (blkOk) begin
                  stb.winLoad = 1'b1;
                  stb.winKind = WIN_PAGE;
                end else begin
                  stb.winClr = 1'b1;
                end
              end
            end else begin
              stb.rdyClr    = 1'b1;
              stb.timerLoad = 1'b1;
              stb.timerSel  = (state == S_RD_CONF) ? DLY_READ :
                              (state == S_PG_CONF) ? DLY_PROG : DLY_ERASE;
              nxt           = S_BUSY;
            end
          end else begin
            undefN = 1'b1;
            nxt    = S_IDLE;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_POWERON;
      opRead   <= 1'b0;
      undefErr <= 1'b0;
      addrErr  <= 1'b0;
    end else begin
      state    <= nxt;
      undefErr <= undefN;
      addrErr  <= addrErrN;
      if (stb.timerLoad) opRead <= (state == S_RD_CONF);
    end
  end

  // R12
  ev_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && addrValid));

  // R12
  ev_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyEv |=> !anyEv);

  // R7
  busy_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY || state == S_RSTBUSY) |-> !rdy);

  // R2
  rst_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && $past(state) == S_RSTBUSY) |-> rdy);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES    = 512,
  parameter int SPARE_BYTES   = 16,
  parameter int PAGES_PER_BLK = 64,
  parameter int NUM_BLOCKS    = 16,
  parameter int COL_BYTES     = 2,
  parameter int ROW_BYTES     = 3,
  parameter int PARAM_BYTES   = 256,
  parameter int DLY_W         = 12,
  parameter int RST_CYCLES    = 8,
  parameter int LEN_W         = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [7:0]             cmdByte,
  input  logic                   addrValid,
  input  logic [7:0]             addrByte,
  input  logic [7:0]             cycleCfg,
  input  logic [DLY_W-1:0]       readDelay,
  input  logic [DLY_W-1:0]       progDelay,
  input  logic [DLY_W-1:0]       eraseDelay,
  input  logic [NUM_BLOCKS-1:0]  badBlkMap,
  input  logic                   wpN,
  output logic [7:0]             status,
  output logic [2:0]             winKind,
  output logic [LEN_W-1:0]       winLen,
  output logic [8*COL_BYTES-1:0] winCol,
  output logic [8*ROW_BYTES-1:0] winRow,
  output logic                   undefErr,
  output logic                   addrErr
);

  seqStb_t  stb;
  logic     colLast, rowLast, timerLast, blkOk, rdy;
  logic [2:0] zeroDly;
  winKind_t kindQ;

  nand_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdByte(cmdByte),
    .addrValid(addrValid), .addrByte(addrByte),
    .colLast(colLast), .rowLast(rowLast), .timerLast(timerLast),
    .blkOk(blkOk), .zeroDly(zeroDly), .rdy(rdy),
    .stb(stb), .undefErr(undefErr), .addrErr(addrErr)
  );

  nand_seq_dp #(
    .PAGE_BYTES(PAGE_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .PAGES_PER_BLK(PAGES_PER_BLK), .NUM_BLOCKS(NUM_BLOCKS),
    .COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES),
    .PARAM_BYTES(PARAM_BYTES), .DLY_W(DLY_W),
    .RST_CYCLES(RST_CYCLES), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .addrByte(addrByte), .cycleCfg(cycleCfg),
    .readDelay(readDelay), .progDelay(progDelay), .eraseDelay(eraseDelay),
    .badBlkMap(badBlkMap), .wpN(wpN),
    .colLast(colLast), .rowLast(rowLast), .timerLast(timerLast),
    .blkOk(blkOk), .zeroDly(zeroDly), .rdy(rdy), .status(status),
    .winKind(kindQ), .winLen(winLen), .winCol(winCol), .winRow(winRow)
  );

  assign winKind = kindQ;

endmodule

// File: tb/nand_cmd_seq_test.sv
`timescale 1ns/1ps
module nand_cmd_seq_test;

  localparam int PAGE_TOTAL = 528;
  localparam int BLK_TOTAL  = 528 * 64;
  localparam int RSTC       = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdByte = 8'h00;
  logic        addrValid = 1'b0;
  logic [7:0]  addrByte = 8'h00;
  logic [7:0]  cycleCfg = 8'h23;
  logic [11:0] readDelay = '0, progDelay = '0, eraseDelay = '0;
  logic [15:0] badBlkMap = '0;
  logic        wpN = 1'b1;
  logic [7:0]  status;
  logic [2:0]  winKind;
  logic [19:0] winLen;
  logic [15:0] winCol;
  logic [23:0] winRow;
  logic        undefErr, addrErr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nand_cmd_seq uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .addrValid(addrValid), .addrByte(addrByte), .cycleCfg(cycleCfg),
    .readDelay(readDelay), .progDelay(progDelay), .eraseDelay(eraseDelay),
    .badBlkMap(badBlkMap), .wpN(wpN), .status(status), .winKind(winKind),
    .winLen(winLen), .winCol(winCol), .winRow(winRow),
    .undefErr(undefErr), .addrErr(addrErr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit blkOkF(logic [23:0] row, logic [15:0] map);
    return (row >> 10) == 0 && !map[row[9:6]];
  endfunction

  task automatic sendCmd(logic [7:0] b);
    @(negedge clk); cmdValid = 1'b1; cmdByte = b;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  task automatic sendAddr(logic [7:0] b);
    @(negedge clk); addrValid = 1'b1; addrByte = b;
    @(negedge clk); addrValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lowCount(output int n);
    n = 0;
    while (status[6] == 1'b0 && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; idle(3); rstN = 1'b1; idle(2);
  endtask

  // op: 0 read, 1 program, 2 erase
  task automatic doOp(int op, int nc, int nr, logic [15:0] col,
                      logic [23:0] row, int dly);
    logic [15:0] colV;
    logic [23:0] rowV;
    bit ok;
    int n;
    cycleCfg = {4'(nc), 4'(nr)};
    colV = '0; rowV = '0;
    for (int k = 0; k < nc; k++) colV[8*k +: 8] = col[8*k +: 8];
    for (int k = 0; k < nr; k++) rowV[8*k +: 8] = row[8*k +: 8];
    ok = blkOkF(rowV, badBlkMap);
    if (op == 0) begin readDelay = 12'(dly); sendCmd(8'h00); end
    else if (op == 1) begin progDelay = 12'(dly); sendCmd(8'h80); end
    else begin eraseDelay = 12'(dly); sendCmd(8'h60); end
    if (op != 2) for (int k = 0; k < nc; k++) sendAddr(col[8*k +: 8]);
    for (int k = 0; k < nr; k++) sendAddr(row[8*k +: 8]);
    idle(2);
    if (op != 0) begin
      chk("R10 fail at address", int'(status[0]), ok ? 0 : 1);
      chk(op == 1 ? "R8 window kind" : "R9 window kind", int'(winKind),
          ok ? (op == 1 ? 4 : 5) : 0);
      if (ok && op == 1) begin
        chk("R4 column", int'(winCol), int'(colV));
        chk("R4 row", int'(winRow), int'(rowV));
      end
      if (ok && op == 2) begin
        chk("R9 length", int'(winLen), BLK_TOTAL);
        chk("R9 row", int'(winRow), int'(rowV));
        chk("R9 column", int'(winCol), 0);
      end
    end
    sendCmd(op == 0 ? 8'h30 : (op == 1 ? 8'h10 : 8'hD0));
    lowCount(n);
    chk(op == 0 ? "R7 busy cycles" : (op == 1 ? "R8 busy cycles" : "R9 busy cycles"),
        n, dly);
    if (op == 0) begin
      chk("R7 window kind", int'(winKind), ok ? 4 : 0);
      chk("R10 read no fail", int'(status[0]), 0);
      if (ok) begin
        chk("R7 length", int'(winLen), PAGE_TOTAL);
        chk("R4 column", int'(winCol), int'(colV));
        chk("R4 row", int'(winRow), int'(rowV));
      end
    end
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    doReset();
    // R1 reset state
    chk("R1 status", int'(status), 8'hC0);
    chk("R1 window", int'(winKind), 0);
    chk("R1 errors", int'(undefErr) + int'(addrErr), 0);
    // R2 reset command
    sendCmd(8'hFF);
    lowCount(n);
    chk("R2 reset busy", n, RSTC);
    chk("R2 window cleared", int'(winKind), 0);
    // R3 reset is undefined in idle
    sendCmd(8'hFF);
    chk("R3 undef in idle", int'(undefErr), 1);
    chk("R3 rdy kept", int'(status[6]), 1);
    // R5
    sendCmd(8'h90); sendAddr(8'h00);
    chk("R5 id kind", int'(winKind), 1);
    chk("R5 id len", int'(winLen), 2);
    sendCmd(8'h90); sendAddr(8'h20);
    chk("R5 sig kind", int'(winKind), 2);
    chk("R5 sig len", int'(winLen), 4);
    sendCmd(8'h90); sendAddr(8'h55);
    chk("R5 bad addr pulse", int'(addrErr), 1);
    chk("R5 window kept", int'(winKind), 2);
    // R6
    sendCmd(8'hEC); sendAddr(8'h00);
    chk("R6 param kind", int'(winKind), 3);
    chk("R6 param len", int'(winLen), 256);
    sendCmd(8'hEC); sendAddr(8'h07);
    chk("R6 bad addr pulse", int'(addrErr), 1);
    // R1 garbage in power-on moves to idle
    doReset();
    sendAddr(8'h12);
    chk("R1 undef in power-on", int'(undefErr), 1);
    sendCmd(8'h90); sendAddr(8'h00);
    chk("R1 idle after undef", int'(winKind), 1);
    // R13
    wpN = 1'b0; idle(1);
    chk("R13 wp bit", int'(status[7]), 0);
    wpN = 1'b1;
    // R10 + R3: program to bad block, then unknown command clears FAIL
    badBlkMap = 16'h0004;
    doOp(1, 2, 2, 16'h0010, 24'h0080, 3);
    sendCmd(8'h42);
    chk("R3 undef cmd", int'(undefErr), 1);
    chk("R3 fail cleared", int'(status[0]), 0);
    // R10 read out of range
    doOp(0, 2, 3, 16'h0001, 24'h010000, 2);
    // R11 extra address bytes ignored
    badBlkMap = '0;
    cycleCfg = 8'h21;
    sendCmd(8'h80); sendAddr(8'h34); sendAddr(8'h12); sendAddr(8'h47);
    idle(2);
    sendAddr(8'hAA); sendAddr(8'hBB);
    chk("R11 row kept", int'(winRow), 8'h47);
    chk("R11 col kept", int'(winCol), 16'h1234);
    progDelay = 12'd4;
    sendCmd(8'h10);
    lowCount(n);
    chk("R11 confirm works", n, 4);
    // R12 wrong confirm
    cycleCfg = 8'h11;
    sendCmd(8'h00); sendAddr(8'h00); sendAddr(8'h01);
    sendCmd(8'h10);
    chk("R12 wrong confirm", int'(undefErr), 1);
    sendCmd(8'h90); sendAddr(8'h00);
    chk("R12 back to idle", int'(winKind), 1);
    // R12 event during busy
    eraseDelay = 12'd50;
    sendCmd(8'h60); sendAddr(8'h40); idle(2);
    sendCmd(8'hD0); idle(5);
    chk("R12 busy low", int'(status[6]), 0);
    sendCmd(8'h90);
    chk("R12 abort pulse", int'(undefErr), 1);
    chk("R12 abort rdy", int'(status[6]), 1);
    // R7 zero delay read
    doOp(0, 2, 2, 16'hBEEF, 24'h0123, 0);
    // random mix
    for (int i = 0; i < 60; i++) begin
      int op, nc, nr, dly;
      logic [23:0] row;
      op  = int'($urandom % 3);
      nc  = 1 + int'($urandom % 2);
      nr  = 1 + int'($urandom % 3);
      dly = int'($urandom % 16);
      row = ($urandom % 2) ? 24'($urandom % 1024) : 24'($urandom);
      badBlkMap = 16'($urandom) & 16'($urandom);
      doOp(op, nc, nr, 16'($urandom), row, dly);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule